// File: doc/BRIEF.md
# Multicycle Accumulator Sequencer

This block is a small accumulator machine. It runs each instruction as a series of states: it fetches the instruction, decodes it, does the operand lookups that the addressing mode needs, and then executes it. Instructions and data share one synchronous memory port. The port has a 16-bit word address and 24-bit words, and a read returns its data one cycle after the request. The machine has four operations: load the accumulator, add to the accumulator, store the accumulator, and stop.

An instruction word carries three fields: an opcode, a two-bit addressing mode and a 16-bit field. The number of data reads depends on the mode. Immediate mode needs none, because the field itself is the operand. Direct mode needs one, because the field is the operand's address. Indirect mode needs two, because the field points to a word whose low 16 bits are the operand's address.

Once a stop instruction (or an unknown opcode) has been decoded, the machine freezes and makes no further memory accesses until reset. The program counter and the accumulator are brought out for observation.

Top module: `acc_seq_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `dbg_pc` and `dbg_acc` are zero, `halted` and `illegal` are low, `mem_we` is low, and that first cycle issues a read at address 0.
- R2: Each instruction begins with one read at the program counter, and the program counter then advances by exactly one. After a stop, `dbg_pc` is one past the address of the stop word.
- R3: In immediate mode (bits 17:16 = 00) the zero-extended 16-bit field (bits 15:0) is the operand, and no data read is issued. A load or add in this mode takes 4 cycles from its fetch to the next fetch.
- R4: In direct mode (bits 17:16 = 01) exactly one data read is issued, at the 16-bit field. A load or add in this mode takes 5 cycles from its fetch to the next fetch.
- R5: In indirect mode (bits 17:16 = 10) a first read at the field returns a pointer word, and a second read at that word's bits 15:0 returns the operand. A load or add takes 7 cycles, and a store takes 6 cycles.
- R6: Opcode 0 loads the operand into the accumulator. Opcode 1 sets the accumulator to (accumulator + operand) mod 2^24.
- R7: Opcode 2 writes the accumulator to the field address in immediate or direct mode, or to the pointer read from the field in indirect mode, and leaves the accumulator unchanged. A store in immediate or direct mode takes 4 cycles.
- R8: The opcode sits in bits 23:18. Mode code 11 is treated exactly as direct.
- R9: Opcode 63 stops the machine. `halted` rises and stays high until reset, `mem_re` and `mem_we` stay low, and `dbg_pc` and `dbg_acc` hold still. No later instruction is executed.
- R10: Any opcode other than 0, 1, 2 or 63 acts as a stop and also raises `illegal`, which stays high until reset. A legal stop leaves `illegal` low.
- R11: `mem_re` and `mem_we` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Word address for the current access |
| mem_re | output | 1 | Read request; data is returned on the next cycle |
| mem_rdata | input | 24 | Read data, valid the cycle after a read request |
| mem_wdata | output | 24 | Write data (the accumulator) |
| mem_we | output | 1 | Write request |
| halted | output | 1 | Machine has stopped |
| illegal | output | 1 | Stop was caused by an unknown opcode |
| dbg_pc | output | 16 | Program counter |
| dbg_acc | output | 24 | Accumulator |

## Verification
Five programs run against a behavioural reference that predicts every memory access and the cycle gap between fetches. The programs cover:
- Immediate chains, which show that no data read is issued in that mode.
- Direct and indirect loads and stores, which separate one lookup from two and show that a store through a pointer lands at the pointer rather than at the field.
- A pointer word with its upper bits set, which shows that only bits 15:0 are used as the address.
- A 24-bit add overflow, which shows the wrap.
- Reserved mode 11, which must match direct mode.
- An unknown opcode, an immediate stop and code placed after a stop, which show that nothing executes past the halt.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

    localparam int ADDR_W   = 16;
    localparam int WORD_W   = 24;
    localparam int OPC_W    = 6;
    localparam int MODE_W   = 2;
    localparam int MODE_LSB = ADDR_W;
    localparam int OPC_LSB  = WORD_W - OPC_W;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'd0;
    localparam logic [OPC_W-1:0] OPC_SUM   = 6'd1;
    localparam logic [OPC_W-1:0] OPC_PUT   = 6'd2;
    localparam logic [OPC_W-1:0] OPC_STOP  = 6'd63;

    typedef enum logic [1:0] {K_LOAD, K_SUM, K_PUT, K_STOP} kind_e;
    typedef enum logic [1:0] {AM_IMM, AM_DIR, AM_IND} amode_e;

    typedef enum logic [2:0] {
        S_FETCH, S_LATCH, S_DECODE, S_PTR, S_DEREF, S_OPND, S_EXEC, S_HALT
    } state_e;

    typedef struct packed {
        kind_e              kind;
        amode_e             mode;
        logic               bad;
        logic [ADDR_W-1:0]  field;
    } dec_t;

    // Mode code 11 is folded onto direct addressing.
    function automatic amode_e map_mode(input logic [MODE_W-1:0] code);
        case (code)
            2'b00:   return AM_IMM;
            2'b10:   return AM_IND;
            default: return AM_DIR;
        endcase
    endfunction

endpackage

// File: rtl/acc_seq_decode.sv
module acc_seq_decode
    import acc_seq_pkg::*;
(
    input  logic [WORD_W-1:0] ir,
    output dec_t              dec
);
    logic [OPC_W-1:0] opc;

    always_comb begin
        opc       = ir[OPC_LSB +: OPC_W];
        dec.field = ir[ADDR_W-1:0];
        dec.mode  = map_mode(ir[MODE_LSB +: MODE_W]);
        dec.bad   = 1'b0;
        case (opc)
            OPC_LOAD: dec.kind = K_LOAD;
            OPC_SUM:  dec.kind = K_SUM;
            OPC_PUT:  dec.kind = K_PUT;
            OPC_STOP: dec.kind = K_STOP;
            default: begin
                dec.kind = K_STOP;
                dec.bad  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu
    import acc_seq_pkg::*;
(
    input  kind_e             kind,
    input  logic [WORD_W-1:0] acc,
    input  logic [WORD_W-1:0] opnd,
    output logic [WORD_W-1:0] res
);
    always_comb begin
        case (kind)
            K_LOAD:  res = opnd;
            K_SUM:   res = acc + opnd;
            default: res = acc;
        endcase
    end
endmodule

// File: rtl/acc_seq_top.sv
module acc_seq_top
    import acc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              halted,
    output logic              illegal,
    output logic [ADDR_W-1:0] dbg_pc,
    output logic [WORD_W-1:0] dbg_acc
);
    localparam int PAD_W = WORD_W - ADDR_W;

    state_e            state;
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] ea;
    logic [WORD_W-1:0] ir;
    logic [WORD_W-1:0] acc;
    logic              bad_q;
    dec_t              dec;
    logic [WORD_W-1:0] opnd;
    logic [WORD_W-1:0] alu_res;

    acc_seq_decode u_dec (.ir(ir), .dec(dec));

    acc_seq_alu u_alu (
        .kind (dec.kind),
        .acc  (acc),
        .opnd (opnd),
        .res  (alu_res)
    );

    assign opnd = (dec.mode == AM_IMM) ? {{PAD_W{1'b0}}, dec.field} : mem_rdata;

    always_comb begin
        mem_addr = pc;
        mem_re   = 1'b0;
        mem_we   = 1'b0;
        case (state)
            S_FETCH: mem_re = 1'b1;
            S_PTR: begin
                mem_addr = dec.field;
                mem_re   = 1'b1;
            end
            S_OPND: begin
                mem_addr = ea;
                mem_re   = 1'b1;
            end
            S_EXEC: begin
                mem_addr = ea;
                mem_we   = (dec.kind == K_PUT);
            end
            default: ;
        endcase
    end

    assign mem_wdata = acc;
    assign halted    = (state == S_HALT);
    assign illegal   = bad_q;
    assign dbg_pc    = pc;
    assign dbg_acc   = acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_FETCH;
            pc    <= '0;
            ea    <= '0;
            ir    <= '0;
            acc   <= '0;
            bad_q <= 1'b0;
        end else begin
            case (state)
                S_FETCH: begin
                    pc    <= pc + 1'b1;
                    state <= S_LATCH;
                end
                S_LATCH: begin
                    ir    <= mem_rdata;
                    state <= S_DECODE;
                end
                S_DECODE: begin
                    ea <= dec.field;
                    if (dec.kind == K_STOP) begin
                        bad_q <= dec.bad;
                        state <= S_HALT;
                    end else if (dec.mode == AM_IND) begin
                        state <= S_PTR;
                    end else if (dec.kind == K_PUT || dec.mode == AM_IMM) begin
                        state <= S_EXEC;
                    end else begin
                        state <= S_OPND;
                    end
                end
                S_PTR:   state <= S_DEREF;
                S_DEREF: begin
                    ea    <= mem_rdata[ADDR_W-1:0];
                    state <= (dec.kind == K_PUT) ? S_EXEC : S_OPND;
                end
                S_OPND:  state <= S_EXEC;
                S_EXEC: begin
                    acc   <= alu_res;
                    state <= S_FETCH;
                end
                default: state <= S_HALT;
            endcase
        end
    end

    // R11: one access kind per cycle
    p_rd_wr_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(mem_re && mem_we));

    // R9: stop is sticky, silent and frozen
    p_halt_hold_r9: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);
    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_re && !mem_we));
    p_halt_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        halted |=> ($stable(dbg_pc) && $stable(dbg_acc)));

    // R10: unknown opcode flag implies a stop and persists
    p_bad_halts_r10: assert property (@(posedge clk) disable iff (rst)
        illegal |-> halted);
    p_bad_hold_r10: assert property (@(posedge clk) disable iff (rst)
        illegal |=> illegal);

    // R2: a fetch advances the program counter by one
    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (state == S_FETCH) |=> (dbg_pc == $past(dbg_pc) + 1'b1));

    // R3: immediate operands cause no data read
    p_imm_noread_r3: assert property (@(posedge clk) disable iff (rst)
        (state == S_DECODE && dec.mode == AM_IMM && dec.kind != K_STOP) |=> !mem_re);

    // R5: the second indirect lookup uses the pointer returned by the first
    p_ind_second_r5: assert property (@(posedge clk) disable iff (rst)
        (state == S_DEREF && dec.kind != K_PUT) |=>
            (mem_re && mem_addr == $past(mem_rdata[ADDR_W-1:0])));

endmodule

// File: tb/acc_seq_top_tb_top.sv
module acc_seq_top_tb_top;
    import acc_seq_pkg::*;

    localparam int MEM_N = 1024;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_re, mem_we;
    logic [WORD_W-1:0] mem_rdata = '0;
    logic [WORD_W-1:0] mem_wdata;
    logic              halted, illegal;
    logic [ADDR_W-1:0] dbg_pc;
    logic [WORD_W-1:0] dbg_acc;

    logic              ld_en = 1'b0;
    logic [9:0]        ld_addr = '0;

    logic [WORD_W-1:0] mem [MEM_N];
    logic [WORD_W-1:0] img [MEM_N];
    int                ref_mem [MEM_N];

    int n_chk = 0;
    int n_bad = 0;
    bit running = 1'b0;
    bit done = 1'b0;
    int cyc = 0;
    int last_fetch = 0;
    int ex_kind[$], ex_addr[$], ex_data[$], ex_gap[$];

    always #5 clk = ~clk;

    acc_seq_top dut_i (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .halted(halted), .illegal(illegal), .dbg_pc(dbg_pc), .dbg_acc(dbg_acc)
    );

    // Environment memory: one-cycle read latency
    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= img[ld_addr];
        else if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[9:0]];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int enc(input int op, input int md, input int f);
        return (op << 18) | (md << 16) | (f & 'hFFFF);
    endfunction

    // Access monitor: compares every access against the reference queue
    always @(negedge clk) begin
        if (running) begin
            cyc++;
            if (mem_re && mem_we) chk(1'b0, "R11 read and write together", 1, 0);
            if (mem_re || mem_we) begin
                if (ex_kind.size() == 0) begin
                    chk(1'b0, "R9 access after stop", int'(mem_addr), -1);
                end else begin
                    int k, a, d, g;
                    k = ex_kind.pop_front();
                    a = ex_addr.pop_front();
                    d = ex_data.pop_front();
                    g = ex_gap.pop_front();
                    if (k == 2) begin
                        chk(mem_we == 1'b1, "R7 write expected", int'(mem_we), 1);
                        chk(int'(mem_addr) == a, "R7 write address", int'(mem_addr), a);
                        chk(int'(mem_wdata) == d, "R7 write data", int'(mem_wdata), d);
                    end else begin
                        chk(mem_re == 1'b1, (k == 0) ? "R2 fetch read" : "R4 data read", int'(mem_re), 1);
                        chk(int'(mem_addr) == a, (k == 0) ? "R2 fetch address" : "R5 data address",
                            int'(mem_addr), a);
                        if (k == 0) begin
                            if (g >= 0) chk(cyc - last_fetch == g, "R3 cycles per instruction",
                                            cyc - last_fetch, g);
                            last_fetch = cyc;
                        end
                    end
                end
            end
        end
    end

    // Behavioural reference: instruction-level interpreter
    task automatic build_ref(output int e_pc, output int e_acc, output int e_ill);
        int pc, acc, gap;
        pc = 0; acc = 0; gap = -1; e_ill = 0;
        for (int step = 0; step < 200; step++) begin
            int w, op, md, f, opnd, p, ea;
            w = ref_mem[pc % MEM_N];
            ex_kind.push_back(0); ex_addr.push_back(pc); ex_data.push_back(0); ex_gap.push_back(gap);
            pc = (pc + 1) & 'hFFFF;
            op = (w >> 18) & 'h3F;
            md = (w >> 16) & 3;
            f  = w & 'hFFFF;
            if (md == 3) md = 1;
            if (op == 0 || op == 1) begin
                if (md == 0) begin
                    opnd = f; gap = 4;
                end else if (md == 1) begin
                    ex_kind.push_back(1); ex_addr.push_back(f); ex_data.push_back(0); ex_gap.push_back(-1);
                    opnd = ref_mem[f % MEM_N]; gap = 5;
                end else begin
                    ex_kind.push_back(1); ex_addr.push_back(f); ex_data.push_back(0); ex_gap.push_back(-1);
                    p = ref_mem[f % MEM_N] & 'hFFFF;
                    ex_kind.push_back(1); ex_addr.push_back(p); ex_data.push_back(0); ex_gap.push_back(-1);
                    opnd = ref_mem[p % MEM_N]; gap = 7;
                end
                acc = (op == 0) ? opnd : ((acc + opnd) & 'hFFFFFF);
            end else if (op == 2) begin
                if (md == 2) begin
                    ex_kind.push_back(1); ex_addr.push_back(f); ex_data.push_back(0); ex_gap.push_back(-1);
                    ea = ref_mem[f % MEM_N] & 'hFFFF; gap = 6;
                end else begin
                    ea = f; gap = 4;
                end
                ex_kind.push_back(2); ex_addr.push_back(ea); ex_data.push_back(acc); ex_gap.push_back(-1);
                ref_mem[ea % MEM_N] = acc;
            end else begin
                e_ill = (op != 63) ? 1 : 0;
                break;
            end
        end
        e_pc = pc; e_acc = acc;
    endtask

    task automatic run_prog(input string name);
        int e_pc, e_acc, e_ill, wait_n, mism;
        @(posedge clk); #1;
        rst = 1'b1; running = 1'b0;
        for (int i = 0; i < MEM_N; i++) begin
            ld_en = 1'b1; ld_addr = 10'(i);
            @(posedge clk); #1;
        end
        ld_en = 1'b0;
        for (int i = 0; i < MEM_N; i++) ref_mem[i] = int'(img[i]);
        ex_kind.delete(); ex_addr.delete(); ex_data.delete(); ex_gap.delete();
        build_ref(e_pc, e_acc, e_ill);
        repeat (2) @(posedge clk);
        #1;
        // R1: values held under reset
        chk(dbg_pc == '0 && dbg_acc == '0, "R1 registers under reset", int'(dbg_acc), 0);
        chk(!halted && !illegal && !mem_we, "R1 flags under reset", int'({halted, illegal, mem_we}), 0);
        @(posedge clk); #1;
        rst = 1'b0; cyc = 0; last_fetch = 0; running = 1'b1;
        #1;
        chk(dbg_pc == '0, "R1 pc after reset", int'(dbg_pc), 0);
        chk(dbg_acc == '0, "R1 acc after reset", int'(dbg_acc), 0);
        chk(!halted && !illegal, "R1 flags after reset", int'({halted, illegal}), 0);
        chk(mem_re && mem_addr == '0, "R1 first read at 0", int'(mem_addr), 0);
        wait_n = 0;
        while (!halted && wait_n < 3000) begin
            @(negedge clk); wait_n++;
        end
        chk(halted == 1'b1, {"R9 halted reached: ", name}, int'(halted), 1);
        repeat (6) @(negedge clk);
        chk(halted == 1'b1, "R9 halted stays high", int'(halted), 1);
        chk(int'(dbg_acc) == e_acc, {"R6 final accumulator: ", name}, int'(dbg_acc), e_acc);
        chk(int'(dbg_pc) == e_pc, {"R2 final pc: ", name}, int'(dbg_pc), e_pc);
        chk(int'(illegal) == e_ill, {"R10 illegal flag: ", name}, int'(illegal), e_ill);
        chk(ex_kind.size() == 0, {"R4 all predicted accesses seen: ", name}, ex_kind.size(), 0);
        mism = 0;
        for (int i = 0; i < MEM_N; i++) if (int'(mem[i]) != ref_mem[i]) mism++;
        chk(mism == 0, {"R7 final memory image: ", name}, mism, 0);
        @(posedge clk); #1;
        running = 1'b0;
    endtask

    task automatic clear_img();
        for (int i = 0; i < MEM_N; i++) img[i] = '0;
    endtask

    initial begin
        // Program A: immediate chain, direct store, reserved mode 11 (R3, R6, R8)
        clear_img();
        img[0] = 24'(enc(0, 0, 5));
        img[1] = 24'(enc(1, 0, 7));
        img[2] = 24'(enc(2, 1, 100));
        img[3] = 24'(enc(1, 3, 100));
        img[4] = 24'(enc(2, 0, 101));
        img[5] = 24'(enc(63, 0, 0));
        run_prog("immediate and reserved mode");

        // Program B: direct/indirect, store through pointer, 24-bit wrap (R4, R5, R6, R7)
        clear_img();
        img[0] = 24'(enc(0, 1, 200));
        img[1] = 24'(enc(1, 2, 201));
        img[2] = 24'(enc(2, 2, 202));
        img[3] = 24'(enc(0, 2, 201));
        img[4] = 24'(enc(1, 1, 203));
        img[5] = 24'(enc(2, 1, 204));
        img[6] = 24'(enc(63, 0, 0));
        img[7] = 24'(enc(0, 0, 9));
        img[200] = 24'h123456;
        img[201] = 24'd200;
        img[202] = 24'd300;
        img[203] = 24'hFFFFFF;
        run_prog("direct and indirect");

        // Program C: unknown opcode stops the run (R10)
        clear_img();
        img[0] = 24'(enc(0, 0, 3));
        img[1] = 24'(enc(5, 0, 0));
        img[2] = 24'(enc(2, 1, 50));
        run_prog("unknown opcode");

        // Program D: pointer word with upper bits set (R5)
        clear_img();
        img[0] = 24'(enc(0, 0, 'hFFFF));
        img[1] = 24'(enc(1, 0, 1));
        img[2] = 24'(enc(1, 2, 210));
        img[3] = 24'(enc(2, 2, 210));
        img[4] = 24'(enc(63, 1, 0));
        img[210] = 24'hFF00D3;
        img[211] = 24'h000001;
        run_prog("pointer truncation");

        // Program E: immediate stop (R9, R2)
        clear_img();
        img[0] = 24'(enc(63, 0, 0));
        img[1] = 24'(enc(0, 0, 1));
        run_prog("immediate stop");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule